// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside a flash-style program controller and guards it. It watches a synchronous write stream made of a valid/ready handshake, a 16-bit address and a 16-bit data word. Programming is held off until a three-write key has arrived in the right order. The first two writes are a fixed address/data pair. The third write goes to the common key address, and its data word selects the action. One value arms programming. One value enters an identification mode. One value leaves that mode.

Once armed, every accepted write is passed on as a program load. Arming ends when the program controller raises `prog_done`, so each program operation has to begin again with the full key. A write that arrives without the key stores nothing and only pulses a timer-start output. While identification mode is on, reads return fixed manufacturer and device codes. For a set number of cycles after entering or leaving that mode, the block reports busy and holds off writes.

Back-pressure rules for the write stream: a write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the settle window is running. The read request is a plain one-cycle strobe with no back-pressure, and its response always comes one cycle later.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, `armed`, `armed_pulse`, `load_accept`, `timer_start`, `id_mode`, `busy` and `rd_valid` are all 0, and `wr_ready` is 1.
- R2: Three accepted writes arm programming: AAAA to 5555, then 5555 to 2AAA, then A0A0 to 5555. After the edge that takes the third write, `armed_pulse` is 1 for exactly one cycle and `armed` is 1.
- R3: While `armed` is 1, each accepted write gives a one-cycle `load_accept` pulse after its edge. `armed` stays 1 until an edge with `prog_done` high, and after that edge it is 0. A later write without the key then gives `timer_start` and no `load_accept`.
- R4: When not armed, an accepted write that is not the expected key step gives a one-cycle `timer_start` pulse and no `load_accept`, and the key sequence returns to its start.
- R5: A write that breaks the sequence but is itself AAAA to 5555 counts as a new first step. It gives no `timer_start`.
- R6: Only address bits 14 to 0 are compared against key addresses, so address D555 matches 5555 and AAAA matches 2AAA.
- R7: A key ending in 9090 to 5555 sets `id_mode`. After the settle window, a read with `rd_addr[0]`=0 returns `rd_data`=001F, and a read with `rd_addr[0]`=1 returns 0026, both with `rd_is_id`=1.
- R8: A key ending in F0F0 to 5555 clears `id_mode`. Reads after the settle window return `rd_is_id`=0 and `rd_data`=0000.
- R9: After the edge that takes an identification entry or exit write, `busy` is 1 and `wr_ready` is 0 for exactly SETTLE_CYC cycles. A read requested while `busy` is 1 returns `rd_busy`=1, `rd_is_id`=0 and `rd_data`=0000.
- R10: Each `rd_en` cycle produces `rd_valid`=1 in the next cycle only.
- R11: Reset clears `id_mode`.
- R12: When a write is accepted on the same edge that `prog_done` is high while armed, the write is dropped. It gives neither `load_accept` nor `timer_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write can be accepted (low during settle) |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| prog_done | input | 1 | Program cycle finished; relocks |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | 16 | Read address |
| armed_pulse | output | 1 | One-cycle pulse when programming is armed |
| armed | output | 1 | Programming armed level |
| load_accept | output | 1 | Pulse: accepted write is program data |
| timer_start | output | 1 | Pulse: unkeyed write started the write timer |
| id_mode | output | 1 | Identification mode active |
| busy | output | 1 | Settle window after mode change |
| rd_valid | output | 1 | Read response valid |
| rd_busy | output | 1 | Read response reports busy |
| rd_is_id | output | 1 | Read response carries an ID code |
| rd_data | output | 16 | Read response data |

## Verification
Every write result (`armed_pulse`, `armed`, `load_accept`, `timer_start`, `id_mode`) is registered at the edge that takes the write. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Read responses likewise appear one edge after `rd_en` and are sampled the same way. The settle window is checked by counting rising edges after the mode write: `busy` must be high after each of the first SETTLE_CYC edges and low after the next one.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {KS_IDLE, KS_ONE, KS_TWO} key_st_e;

  localparam int NSTEP = 5;
  typedef enum int {ST_FIRST = 0, ST_SECOND = 1, ST_ARM = 2, ST_ID_IN = 3, ST_ID_OUT = 4} step_e;

  function automatic logic [15:0] step_addr(input int idx);
    return (idx == ST_SECOND) ? 16'h2AAA : 16'h5555;
  endfunction

  function automatic logic [15:0] step_data(input int idx);
    case (idx)
      ST_FIRST:  return 16'hAAAA;
      ST_SECOND: return 16'h5555;
      ST_ARM:    return 16'hA0A0;
      ST_ID_IN:  return 16'h9090;
      default:   return 16'hF0F0;
    endcase
  endfunction
endpackage

// File: rtl/useq_key_match.sv
module useq_key_match
  import useq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int KEY_AW = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NSTEP-1:0]  hit
);
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    localparam logic [15:0] KA = step_addr(g);
    localparam logic [15:0] KD = step_data(g);
    assign hit[g] = (addr[KEY_AW-1:0] == KA[KEY_AW-1:0]) && (data == KD[DATA_W-1:0]);
  end
endmodule

// File: rtl/useq_settle.sv
module useq_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(SETTLE_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/useq_id_read.sv
module useq_id_read #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0026
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              id_mode,
  output logic              rd_valid,
  output logic              rd_busy,
  output logic              rd_is_id,
  output logic [DATA_W-1:0] rd_data
);
  logic serve_id;
  assign serve_id = rd_en && !busy && id_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_busy  <= 1'b0;
      rd_is_id <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_busy  <= rd_en && busy;
      rd_is_id <= serve_id;
      rd_data  <= serve_id ? (rd_addr[0] ? DEV_CODE : MFR_CODE) : '0;
    end
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int KEY_AW     = 15,
  parameter int SETTLE_CYC = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0026
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              armed_pulse,
  output logic              armed,
  output logic              load_accept,
  output logic              timer_start,
  output logic              id_mode,
  output logic              busy,
  output logic              rd_valid,
  output logic              rd_busy,
  output logic              rd_is_id,
  output logic [DATA_W-1:0] rd_data
);
  logic [NSTEP-1:0] hit;
  key_st_e ks, ks_nx;
  logic wr_fire, do_arm, do_idin, do_idout, do_timer, settle_go;

  useq_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_AW(KEY_AW)) u_match (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  always_comb begin
    ks_nx    = ks;
    do_arm   = 1'b0;
    do_idin  = 1'b0;
    do_idout = 1'b0;
    do_timer = 1'b0;
    if (wr_fire && !armed) begin
      unique case (ks)
        KS_ONE:  if (hit[ST_SECOND]) ks_nx = KS_TWO;
                 else if (hit[ST_FIRST]) ks_nx = KS_ONE;
                 else begin ks_nx = KS_IDLE; do_timer = 1'b1; end
        KS_TWO: begin
          ks_nx = KS_IDLE;
          if (hit[ST_ARM])          do_arm   = 1'b1;
          else if (hit[ST_ID_IN])   do_idin  = 1'b1;
          else if (hit[ST_ID_OUT])  do_idout = 1'b1;
          else if (hit[ST_FIRST])   ks_nx    = KS_ONE;
          else                      do_timer = 1'b1;
        end
        default: if (hit[ST_FIRST]) ks_nx = KS_ONE;
                 else do_timer = 1'b1;
      endcase
    end
  end

  assign settle_go = do_idin || do_idout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ks          <= KS_IDLE;
      armed       <= 1'b0;
      armed_pulse <= 1'b0;
      load_accept <= 1'b0;
      timer_start <= 1'b0;
      id_mode     <= 1'b0;
    end else begin
      ks          <= ks_nx;
      armed_pulse <= do_arm;
      timer_start <= do_timer;
      load_accept <= wr_fire && armed && !prog_done;
      if (prog_done)   armed <= 1'b0;
      else if (do_arm) armed <= 1'b1;
      if (do_idin)       id_mode <= 1'b1;
      else if (do_idout) id_mode <= 1'b0;
    end
  end

  useq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(settle_go), .busy(busy)
  );

  useq_id_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .id_mode(id_mode),
    .rd_valid(rd_valid), .rd_busy(rd_busy), .rd_is_id(rd_is_id), .rd_data(rd_data)
  );
endmodule

// File: rtl/useq_chk.sv
module useq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ready,
  input logic prog_done,
  input logic rd_en,
  input logic armed_pulse,
  input logic armed,
  input logic load_accept,
  input logic timer_start,
  input logic busy,
  input logic rd_valid,
  input logic rd_busy,
  input logic rd_is_id
);
  // R2
  arm_pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_pulse |-> armed);
  // R2
  arm_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_pulse |=> !armed_pulse);
  // R3
  done_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !armed);
  // R3
  load_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |-> armed);
  // R4
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_accept, timer_start, armed_pulse}));
  // R9
  busy_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
  // R9
  busy_read_not_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> !rd_is_id);
  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind unlock_seq_decoder useq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .prog_done(prog_done), .rd_en(rd_en),
  .armed_pulse(armed_pulse), .armed(armed), .load_accept(load_accept),
  .timer_start(timer_start), .busy(busy), .rd_valid(rd_valid), .rd_busy(rd_busy),
  .rd_is_id(rd_is_id)
);

// File: tb/unlock_seq_decoder_test.sv
module unlock_seq_decoder_test;
  localparam int SETTLE = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, prog_done = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic wr_ready, armed_pulse, armed, load_accept, timer_start, id_mode, busy;
  logic rd_valid, rd_busy, rd_is_id;
  logic [15:0] rd_data;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  unlock_seq_decoder #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .rd_en(rd_en), .rd_addr(rd_addr),
    .armed_pulse(armed_pulse), .armed(armed), .load_accept(load_accept),
    .timer_start(timer_start), .id_mode(id_mode), .busy(busy), .rd_valid(rd_valid),
    .rd_busy(rd_busy), .rd_is_id(rd_is_id), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_valid = 0; rd_en = 0; prog_done = 0;
    tick(); tick();
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic done = 1'b0);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d; prog_done = done;
    tick();
    @(negedge clk); wr_valid = 0; prog_done = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    tick();
    @(negedge clk); rd_en = 0;
  endtask

  task automatic key2();
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555);
  endtask

  task automatic wait_settle();
    for (int i = 0; i < SETTLE + 1; i++) tick();
  endtask

  task automatic t_reset();
    do_reset(); tick();
    chk("R1 armed", armed, 0); chk("R1 id_mode", id_mode, 0);
    chk("R1 busy", busy, 0); chk("R1 wr_ready", wr_ready, 1);
    chk("R1 pulses", {armed_pulse, load_accept, timer_start, rd_valid}, 0);
  endtask

  task automatic t_arm_and_load();
    key2();
    @(negedge clk); wr_valid = 1; wr_addr = 16'h5555; wr_data = 16'hA0A0;
    tick();
    chk("R2 armed_pulse", armed_pulse, 1); chk("R2 armed", armed, 1);
    @(negedge clk); wr_valid = 0;
    tick();
    chk("R2 pulse one cycle", armed_pulse, 0);
    @(negedge clk); wr_valid = 1; wr_addr = 16'h0103; wr_data = 16'h1234;
    tick();
    chk("R3 load_accept", load_accept, 1); chk("R3 no timer", timer_start, 0);
    @(negedge clk); wr_valid = 0; prog_done = 1;
    tick();
    chk("R3 still armed before done edge", load_accept, 0);
    @(negedge clk); prog_done = 0;
    chk("R3 relock", armed, 0);
    @(negedge clk); wr_valid = 1; wr_addr = 16'h0104; wr_data = 16'h0;
    tick();
    chk("R3 unkeyed after done timer", timer_start, 1); chk("R3 no load after done", load_accept, 0);
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic t_unkeyed();
    @(negedge clk); wr_valid = 1; wr_addr = 16'h0010; wr_data = 16'hBEEF;
    tick();
    chk("R4 timer_start", timer_start, 1); chk("R4 no load", load_accept, 0);
    @(negedge clk); wr_valid = 0;
    tick(); chk("R4 timer one cycle", timer_start, 0);
    // break after first step, then completing the old sequence must fail
    wr(16'h5555, 16'hAAAA); wr(16'h1111, 16'h2222);
    wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'hA0A0);
    chk("R4 broken sequence not armed", armed, 0);
  endtask

  task automatic t_restart();
    wr(16'h5555, 16'hAAAA);
    @(negedge clk); wr_valid = 1; wr_addr = 16'h5555; wr_data = 16'hAAAA;
    tick(); chk("R5 restart no timer", timer_start, 0);
    @(negedge clk); wr_valid = 0;
    wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'hA0A0);
    chk("R5 restart arms", armed, 1);
    wr(16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic t_addr15();
    wr(16'hD555, 16'hAAAA); wr(16'hAAAA, 16'h5555); wr(16'hD555, 16'hA0A0);
    chk("R6 bit15 ignored", armed, 1);
    wr(16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic t_done_priority();
    key2(); wr(16'h5555, 16'hA0A0);
    @(negedge clk); wr_valid = 1; wr_addr = 16'h0200; wr_data = 16'h5A5A; prog_done = 1;
    tick();
    chk("R12 dropped load", load_accept, 0); chk("R12 dropped timer", timer_start, 0);
    chk("R12 relock", armed, 0);
    @(negedge clk); wr_valid = 0; prog_done = 0;
  endtask

  task automatic t_id_enter();
    key2();
    @(negedge clk); wr_valid = 1; wr_addr = 16'h5555; wr_data = 16'h9090;
    tick();
    chk("R7 id_mode", id_mode, 1); chk("R9 busy", busy, 1); chk("R9 ready low", wr_ready, 0);
    @(negedge clk); wr_valid = 0; rd_en = 1; rd_addr = 16'h0000;
    tick();
    chk("R9 read busy", rd_busy, 1); chk("R9 busy read not id", rd_is_id, 0);
    chk("R10 rd_valid", rd_valid, 1);
    @(negedge clk); rd_en = 0;
    for (int i = 2; i < SETTLE; i++) tick();
    chk("R9 busy last cycle", busy, 1);
    tick(); chk("R9 busy ends", busy, 0); chk("R9 ready back", wr_ready, 1);
    chk("R10 rd_valid one cycle", rd_valid, 0);
    rd(16'h0000);
    chk("R7 mfr", rd_data, 16'h001F); chk("R7 rd_is_id", rd_is_id, 1);
    rd(16'h0001);
    chk("R7 dev", rd_data, 16'h0026);
  endtask

  task automatic t_id_exit();
    key2(); wr(16'h5555, 16'hF0F0);
    chk("R8 id_mode cleared", id_mode, 0); chk("R9 busy on exit", busy, 1);
    wait_settle();
    rd(16'h0001);
    chk("R8 not id", rd_is_id, 0); chk("R8 data zero", rd_data, 16'h0000);
  endtask

  task automatic t_reset_id();
    key2(); wr(16'h5555, 16'h9090);
    chk("R11 entered", id_mode, 1);
    do_reset(); tick();
    chk("R11 reset clears id", id_mode, 0);
  endtask

  initial begin
    t_reset();
    t_arm_and_load();
    t_unkeyed();
    t_restart();
    t_addr15();
    t_done_priority();
    t_id_enter();
    t_id_exit();
    t_reset_id();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule